// File: doc/BRIEF.md
# I2C Bus Master with Arbitration Fallback

This block is a byte-level I2C master engine. Software loads a target address and a direction and then pulses a start request. The engine waits until no other device holds the bus. It then issues a START condition and clocks out the address byte, with the direction in its lowest bit. After that it pauses with SCL held low. In that pause the controlling logic asks for one more data byte, either written or read, or asks for a STOP. Each SCL high phase and each SCL low phase lasts `half_div` system clocks. The engine drives its outputs as open-drain enables: a 1 on an enable pulls that line low.

While the engine sends, it compares the bus level with the bit it released. If it lets SDA float high and reads it back low at the end of an SCL high phase, another master has won the bus. The engine then lets go of both lines in that same cycle. If the lost byte was the address byte, the engine keeps shifting the rest of it from the foreign SCL edges. It pulses a match flag when the seven address bits equal its own address, so the slave side of the chip can still answer in that transfer.

Top module: `i2c_master_arb`

## Requirements
- R1: After reset both open-drain enables are 0, and `master`, `bus_busy`, `byte_done`, `arb_lost` and `addr_match` are 0.
- R2: A start request made while `bus_busy` is 1 leaves both enables at 0 and `master` at 0. The START follows only after the bus is seen free.
- R3: START pulls SDA low while SCL is high and keeps SCL high for `half_div` clocks. SCL is then pulled low.
- R4: Every SCL high phase that the engine produces lasts exactly `half_div` clocks. SDA changes only while SCL is low, except during START and STOP. Behaviour is defined for `half_div` of at least 2.
- R5: The first byte is `{slave_addr, read_mode}`, sent MSB first. `read_mode` = 1 selects a read. After the ninth clock, `nack_rcvd` holds the SDA level sampled on that clock (1 = not acknowledged). `byte_done` pulses for one cycle and SCL stays low until the next command.
- R6: On `byte_req` during a write transfer, `tx_data` is sent MSB first and its acknowledge bit is sampled as in R5.
- R7: On `byte_req` during a read transfer, the engine leaves SDA released for eight clocks and builds `rx_data` MSB first. It drives the ninth bit with `ack_next` (0 pulls SDA low to acknowledge, 1 leaves it high). `tx_data` has no effect on the bus.
- R8: On `stop_req` in the pause, SDA is pulled low while SCL is low, then SCL is released, then SDA is released while SCL is high. `master` returns to 0.
- R9: If the engine releases SDA for an address or write bit and samples it low at the end of that SCL high phase, `arb_lost` pulses. In that same cycle both enables and `master` go to 0.
- R10: After losing arbitration in the address byte, the engine shifts the remaining address bits on SCL rising edges driven by the other master. It pulses `addr_match` when the seven address bits equal `own_addr`. This includes a loss on the last address bit.
- R11: `bus_busy` becomes 1 one clock after any START on the bus and 0 one clock after any STOP, whichever master caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | Length of each SCL phase in clocks (at least 2) |
| own_addr | input | 7 | Address compared after lost arbitration |
| start_req | input | 1 | Pulse: begin a transfer |
| slave_addr | input | 7 | Target address for the next transfer |
| read_mode | input | 1 | Direction bit of the address byte (1 = read) |
| tx_data | input | 8 | Byte to send on the next write request |
| byte_req | input | 1 | Pulse in the pause: transfer one more data byte |
| ack_next | input | 1 | Acknowledge level driven after the next received byte |
| stop_req | input | 1 | Pulse in the pause: finish with STOP |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last byte received in a read |
| nack_rcvd | output | 1 | Acknowledge level sampled after the last sent byte |
| byte_done | output | 1 | One-cycle pulse when a byte and its acknowledge bit are complete |
| bus_busy | output | 1 | Bus held between a START and a STOP |
| master | output | 1 | Engine currently owns the bus |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |
| addr_match | output | 1 | One-cycle pulse when the contested address equals own_addr |

## Verification
Some rules are checked by assertions on every cycle. SDA never changes under a released SCL outside START and STOP. The engine becomes master only after a cycle in which the bus was free. It is released completely when arbitration is lost. It is always seen as busy while clocking a bit. The bench follows the bus on every clock with a behavioural model of START and STOP, so it can compare `bus_busy` and measure every high phase. The scenarios then cover what needs a partner on the bus: the bit streams of write, read and refused-address transfers, the acknowledge levels in both directions, deferral behind a foreign START, and arbitration lost early or on the final address bit, each with and without a match on the contested address.

// File: rtl/i2c_master_arb.sv
module i2c_master_arb #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic [6:0]       own_addr,
  input  logic             start_req,
  input  logic [6:0]       slave_addr,
  input  logic             read_mode,
  input  logic [7:0]       tx_data,
  input  logic             byte_req,
  input  logic             ack_next,
  input  logic             stop_req,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [7:0]       rx_data,
  output logic             nack_rcvd,
  output logic             byte_done,
  output logic             bus_busy,
  output logic             master,
  output logic             arb_lost,
  output logic             addr_match
);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_STA, S_LO, S_HI, S_HOLD, S_SP1, S_SP2, S_SP3, S_SLV
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       bcnt;
  logic [7:0]       shreg;
  logic             rd, addr_ph, ack_bit;
  logic             scl_q, sda_q;

  wire       tick      = (cnt == '0);
  wire       first     = (cnt == half_div - DIV_W'(1));
  wire       sending   = addr_ph || !rd;
  wire       drv_bit   = bcnt[3] ? (sending ? 1'b1 : ack_bit) : (sending ? shreg[7] : 1'b1);
  wire       bus_start = scl_q && scl_i && sda_q && !sda_i;
  wire       bus_stop  = scl_q && scl_i && !sda_q && sda_i;
  wire       scl_rise  = !scl_q && scl_i;
  wire [7:0] shin      = {shreg[6:0], sda_i};

  assign master = !(st == S_IDLE || st == S_WAIT || st == S_SLV);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (bus_start)     bus_busy <= 1'b1;
      else if (bus_stop) bus_busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      rd         <= 1'b0;
      addr_ph    <= 1'b0;
      ack_bit    <= 1'b1;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      rx_data    <= '0;
      nack_rcvd  <= 1'b0;
      byte_done  <= 1'b0;
      arb_lost   <= 1'b0;
      addr_match <= 1'b0;
    end else begin
      byte_done  <= 1'b0;
      arb_lost   <= 1'b0;
      addr_match <= 1'b0;
      if (!tick) cnt <= cnt - DIV_W'(1);
      case (st)
        S_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (start_req) begin
            shreg <= {slave_addr, read_mode};
            rd    <= read_mode;
            st    <= S_WAIT;
          end
        end
        S_WAIT:
          if (!bus_busy && scl_i && sda_i) begin
            sda_oe <= 1'b1;
            cnt    <= half_div - DIV_W'(1);
            st     <= S_STA;
          end
        S_STA:
          if (tick) begin
            scl_oe  <= 1'b1;
            cnt     <= half_div - DIV_W'(1);
            bcnt    <= '0;
            addr_ph <= 1'b1;
            st      <= S_LO;
          end
        S_LO: begin
          if (first) sda_oe <= !drv_bit;
          if (tick) begin
            scl_oe <= 1'b0;
            cnt    <= half_div - DIV_W'(1);
            st     <= S_HI;
          end
        end
        S_HI:
          if (tick) begin
            if (!bcnt[3]) begin
              shreg <= shin;
              bcnt  <= bcnt + 4'd1;
              if (sending && shreg[7] && !sda_i) begin
                arb_lost <= 1'b1;
                scl_oe   <= 1'b0;
                sda_oe   <= 1'b0;
                if (addr_ph && bcnt == 4'd7) begin
                  addr_match <= (shin[7:1] == own_addr);
                  st         <= S_IDLE;
                end else begin
                  st <= addr_ph ? S_SLV : S_IDLE;
                end
              end else begin
                scl_oe <= 1'b1;
                cnt    <= half_div - DIV_W'(1);
                st     <= S_LO;
              end
            end else begin
              if (sending) nack_rcvd <= sda_i;
              else         rx_data   <= shreg;
              byte_done <= 1'b1;
              addr_ph   <= 1'b0;
              scl_oe    <= 1'b1;
              st        <= S_HOLD;
            end
          end
        S_HOLD: begin
          scl_oe <= 1'b1;
          if (byte_req) begin
            shreg   <= tx_data;
            ack_bit <= ack_next;
            bcnt    <= '0;
            cnt     <= half_div - DIV_W'(1);
            st      <= S_LO;
          end else if (stop_req) begin
            cnt <= half_div - DIV_W'(1);
            st  <= S_SP1;
          end
        end
        S_SP1: begin
          if (first) sda_oe <= 1'b1;
          if (tick) begin
            scl_oe <= 1'b0;
            cnt    <= half_div - DIV_W'(1);
            st     <= S_SP2;
          end
        end
        S_SP2:
          if (tick) begin
            sda_oe <= 1'b0;
            cnt    <= half_div - DIV_W'(1);
            st     <= S_SP3;
          end
        S_SP3:
          if (tick) st <= S_IDLE;
        S_SLV: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (bus_stop) begin
            st <= S_IDLE;
          end else if (scl_rise) begin
            shreg <= shin;
            bcnt  <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              addr_match <= (shin[7:1] == own_addr);
              st         <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  // R4: SDA moves under a released SCL only when forming START or STOP
  a_r4_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_oe) || $past(st) == S_WAIT || $past(st) == S_SP2));

  a_r4_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> half_div >= DIV_W'(2));

  a_r2_free_before_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> !$past(bus_busy));

  a_r9_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!scl_oe && !sda_oe && !master));

  a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_done, arb_lost}));

  a_r11_busy_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LO) |-> bus_busy);

endmodule

// File: tb/test_i2c_master_arb.sv
module test_i2c_master_arb;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h5A;
  localparam logic [6:0] OWN = 7'h4C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       start_req = 0, read_mode = 0, byte_req = 0, ack_next = 0, stop_req = 0;
  logic [6:0] slave_addr = '0;
  logic [7:0] tx_data = '0;
  logic       rv_scl = 0, rv_pull = 0, sl_pull = 0;
  logic       scl_oe, sda_oe, nack_rcvd, byte_done, bus_busy, master, arb_lost, addr_match;
  logic [7:0] rx_data;

  wire scl = !(scl_oe || rv_scl);
  wire sda = !(sda_oe || sl_pull || rv_pull);

  i2c_master_arb #(.DIV_W(8)) i_i2c_master_arb (
    .clk(clk), .rst_n(rst_n), .half_div(8'(DIV)), .own_addr(OWN),
    .start_req(start_req), .slave_addr(slave_addr), .read_mode(read_mode),
    .tx_data(tx_data), .byte_req(byte_req), .ack_next(ack_next), .stop_req(stop_req),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
    .nack_rcvd(nack_rcvd), .byte_done(byte_done), .bus_busy(bus_busy), .master(master),
    .arb_lost(arb_lost), .addr_match(addr_match));

  int m_cmp = 0, m_bad = 0, s_cmp = 0, s_bad = 0;
  int cyc = 0, sbit = 0, hi_len = 0, p = 0, b = 0, n_match = 0;
  bit m_busy = 0, pscl = 1, psda = 1, hi_valid = 0, hit = 0, dir = 0, slave_en = 1;
  bit bq[$];
  bit exp_q[$];
  logic [7:0] rd_bytes [4];

  task automatic chk_m(input bit ok, input string req, input string what, input int act, input int expv);
    m_cmp++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  task automatic chk_s(input bit ok, input string req, input string what, input int act, input int expv);
    s_cmp++;
    if (!ok) begin
      s_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; pscl = scl; psda = sda; hi_valid = 0; sbit = 0; sl_pull = 0;
    end else begin
      cyc++;
      if (cyc > 50000) begin
        m_bad++;
        $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", m_cmp + s_cmp, m_bad + s_bad);
        $finish;
      end
      chk_m(bus_busy == m_busy, "R11", "bus_busy", bus_busy, m_busy);
      if (arb_lost) chk_m(!scl_oe && !sda_oe && !master, "R9", "release on loss",
                          {scl_oe, sda_oe, master}, 0);
      if (addr_match) n_match++;
      if (pscl && scl && psda && !sda) begin
        m_busy = 1; bq.delete(); sbit = 0; hit = 0; dir = 0; hi_len = 1; hi_valid = 1;
      end else if (pscl && scl && !psda && sda) begin
        m_busy = 0; sl_pull = 0;
      end else if (!pscl && scl) begin
        bq.push_back(sda); sbit++; hi_len = 1; hi_valid = 1;
      end else if (pscl && scl) begin
        hi_len++;
      end else if (pscl && !scl) begin
        if (hi_valid && master) chk_m(hi_len == DIV, "R4", "SCL high length", hi_len, DIV);
        hi_valid = 0;
        p = sbit % 9;
        b = sbit / 9;
        sl_pull = 0;
        if (slave_en) begin
          if (b == 0 && p == 8) begin
            hit = ({bq[0], bq[1], bq[2], bq[3], bq[4], bq[5], bq[6]} == SLV);
            dir = bq[7];
            sl_pull = hit;
          end else if (b > 0 && hit) begin
            if (!dir) sl_pull = (p == 8);
            else if (p < 8 && b <= 4 && !(b >= 2 && bq[9*b-1])) sl_pull = !rd_bytes[b-1][7-p];
          end
        end
      end
      pscl = scl;
      psda = sda;
    end
  end

  task automatic push_byte(input logic [7:0] v, input bit ack);
    for (int k = 7; k >= 0; k--) exp_q.push_back(v[k]);
    exp_q.push_back(ack);
  endtask

  task automatic cmp_bus(input string req);
    chk_s(bq.size() >= exp_q.size(), req, "bus bit count", bq.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < bq.size(); k++)
      chk_s(bq[k] == exp_q[k], req, $sformatf("bus bit %0d", k), bq[k], exp_q[k]);
    exp_q.delete();
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!byte_done);
  endtask

  task automatic do_start(input logic [6:0] a, input bit r);
    @(negedge clk);
    slave_addr = a; read_mode = r; start_req = 1;
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic do_byte(input logic [7:0] d, input bit an);
    @(negedge clk);
    tx_data = d; ack_next = an; byte_req = 1;
    @(negedge clk);
    byte_req = 0;
    wait_done();
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    while (master) @(negedge clk);
    repeat (DIV + 2) @(negedge clk);
    chk_s(!m_busy && scl && sda, "R8", "bus free after STOP", {m_busy, scl, sda}, 3'b011);
  endtask

  task automatic rival(input logic [7:0] rb, output int lostbit);
    lostbit = -1;
    while (!(master && !sda)) @(negedge clk);
    for (int i = 0; i < 8 && lostbit < 0; i++) begin
      while (scl) @(negedge clk);
      rv_pull = !rb[7-i];
      while (!scl) @(negedge clk);
      while (scl && !arb_lost) @(negedge clk);
      if (arb_lost) lostbit = i;
    end
    if (lostbit >= 0) begin
      for (int j = lostbit + 1; j <= 8; j++) begin
        rv_scl = 1;
        @(negedge clk);
        rv_pull = (j < 8) ? !rb[7-j] : 1'b0;
        repeat (DIV - 1) @(negedge clk);
        rv_scl = 0;
        repeat (DIV) @(negedge clk);
      end
      rv_scl = 1;
      @(negedge clk);
      rv_pull = 1;
      repeat (DIV - 1) @(negedge clk);
      rv_scl = 0;
      repeat (DIV) @(negedge clk);
      rv_pull = 0;
      repeat (DIV) @(negedge clk);
    end
  endtask

  initial begin
    int lb;
    int nm;
    rd_bytes[0] = 8'hA5; rd_bytes[1] = 8'h3C; rd_bytes[2] = 8'hFF; rd_bytes[3] = 8'hFF;
    repeat (3) @(negedge clk);
    chk_s(!scl_oe && !sda_oe && !master && !bus_busy && !byte_done && !arb_lost && !addr_match,
          "R1", "reset outputs", {scl_oe, sda_oe, master, bus_busy}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5 R6: write two bytes
    do_start(SLV, 0);
    wait_done();
    chk_s(nack_rcvd == 0, "R5", "address ack", nack_rcvd, 0);
    chk_s(scl == 0, "R5", "SCL held low in pause", scl, 0);
    do_byte(8'hC3, 0);
    chk_s(nack_rcvd == 0, "R6", "data ack", nack_rcvd, 0);
    do_byte(8'h01, 0);
    do_stop();
    push_byte({SLV, 1'b0}, 0); push_byte(8'hC3, 0); push_byte(8'h01, 0);
    cmp_bus("R6");

    // R7: read two bytes, ACK then NACK; tx_data must stay off the bus
    do_start(SLV, 1);
    wait_done();
    chk_s(nack_rcvd == 0, "R5", "read address ack", nack_rcvd, 0);
    do_byte(8'h00, 0);
    chk_s(rx_data == 8'hA5, "R7", "first read byte", rx_data, 8'hA5);
    do_byte(8'h00, 1);
    chk_s(rx_data == 8'h3C, "R7", "second read byte", rx_data, 8'h3C);
    do_stop();
    push_byte({SLV, 1'b1}, 0); push_byte(8'hA5, 0); push_byte(8'h3C, 1);
    cmp_bus("R7");

    // R5: address nobody answers
    do_start(7'h11, 0);
    wait_done();
    chk_s(nack_rcvd == 1, "R5", "address refused", nack_rcvd, 1);
    do_stop();
    push_byte({7'h11, 1'b0}, 1);
    cmp_bus("R5");

    // R2: a foreign START holds the engine off until the foreign STOP
    @(negedge clk);
    rv_pull = 1;
    repeat (3) @(negedge clk);
    do_start(SLV, 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk_s(!scl_oe && !sda_oe && !master, "R2", "quiet while bus busy",
            {scl_oe, sda_oe, master}, 0);
    end
    rv_pull = 0;
    wait_done();
    chk_s(nack_rcvd == 0, "R2", "transfer after bus freed", nack_rcvd, 0);
    do_stop();
    push_byte({SLV, 1'b0}, 0);
    cmp_bus("R3");

    // R9 R10: lost on bit 1, rival addresses this engine
    slave_en = 0;
    nm = n_match;
    do_start(7'h70, 0);
    rival({OWN, 1'b0}, lb);
    chk_s(lb == 1, "R9", "loss position", lb, 1);
    chk_s(n_match == nm + 1, "R10", "match after early loss", n_match - nm, 1);
    chk_s(!master && !m_busy, "R10", "idle after rival STOP", {master, m_busy}, 0);

    // R10: lost on bit 1, rival addresses someone else
    nm = n_match;
    do_start(7'h70, 0);
    rival({7'h48, 1'b0}, lb);
    chk_s(lb == 1, "R9", "loss position, other address", lb, 1);
    chk_s(n_match == nm, "R10", "no match for other address", n_match - nm, 0);

    // R10: lost on the direction bit, address still matches
    nm = n_match;
    do_start(OWN, 1);
    rival({OWN, 1'b0}, lb);
    chk_s(lb == 7, "R9", "loss on final bit", lb, 7);
    chk_s(n_match == nm + 1, "R10", "match after last-bit loss", n_match - nm, 1);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", m_cmp + s_cmp, m_bad + s_bad);
    $finish;
  end
endmodule